// File: doc/BRIEF.md
# External Interrupt Line Controller

This block collects up to 32 asynchronous interrupt request pins and turns them into one maskable interrupt request for a processor, plus a separate non-maskable request fed by line 0. Each pin is brought into the clock domain through two flip-flops. It is then judged against a sense rule chosen per line: a high level, a low level, a rising edge or a falling edge. A matching event latches a per-line status bit, which stays set until software writes a one to clear it.

Software uses a small register bus with a single select, a write strobe, a byte address and 32-bit data. Enables are changed through a pair of write-one strobe words, one for setting and one for clearing, so no read-modify-write is needed. A readback word shows the current enables. The sense rule of each line comes from three bit-vectors: a mode vector chooses level or edge, and two polarity vectors give the active level and the active edge. The number of lines built is a parameter. Software finds it by writing all ones to the mode vector and reading the vector back. Which line to serve first is left to software.

Top module: `xint_ctrl`

## Requirements
- R1: After reset, the mode vector reads with a 1 for every implemented line, the edge-polarity vector, the level-polarity vector, the enable readback and the NMI control word read 0, and irq_out and nmi_out are 0. Every line therefore starts out sensing a low level.
- R2: A write to enable-set (offset 0x00) sets the enable of each line whose data bit is 1. A write to enable-clear (offset 0x04) clears the enable of each line whose data bit is 1. Data bits of 0 leave the enables unchanged.
- R3: A read of offset 0x08 returns the current enable vector. A read of offset 0x0C returns the latched status vector. Read data appears on bus_rdata in the cycle after the read strobe.
- R4: A write to status-clear (offset 0x10) clears each status bit whose data bit is 1 and leaves the other status bits as they are.
- R5: A line is in level mode when its mode bit (offset 0x14) is 1. Its level-polarity bit (offset 0x1C) then picks active high (1) or active low (0), and the status bit is set in every cycle in which the synchronized input is at the active level.
- R6: A line is in edge mode when its mode bit is 0. Its edge-polarity bit (offset 0x18) then picks the rising edge (1) or the falling edge (0). The status bit is set by an edge of the chosen kind and stays set after the input goes back.
- R7: An input change that is sampled at clock edge k sets the status bit at edge k+2, and irq_out rises at edge k+3.
- R8: In level mode, a status bit that is cleared while its input is still active reads 0 in the next cycle and is set again one cycle later.
- R9: If an edge event falls in the same cycle as a status-clear write to that line, the event wins and the status bit stays set.
- R10: irq_out is a registered copy of the OR, over all lines, of status AND enable.
- R11: nmi_out is a registered copy of (bit 0 of the NMI control word at offset 0x24) AND (status bit 0), and it does not depend on the enable of line 0.
- R12: Bits above NUM_LINES in the mode, edge, level, enable and status words read 0, and writes to those bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| ext_in | input | NUM_LINES | Asynchronous interrupt request pins |
| irq_out | output | 1 | Combined maskable interrupt request |
| nmi_out | output | 1 | Non-maskable request from line 0 |

## Verification
Two functions can act in the same cycle: a latching event on a line and a status-clear write aimed at that line. The bench sets up an edge-mode line, changes its input, and counts the register stages so that the clear write lands on exactly the clock edge at which the synchronized edge is detected. It then reads the status back and expects the bit still set. A second case places a clear on a level-mode line that is still active. There the clear takes effect for one cycle, and two reads back to back must show 0 and then 1.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_EN_SET = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_EN_RD  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_ST_CLR = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_EDGE   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_LEVEL  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_NMI    = 8'h24;

  typedef enum logic [1:0] {
    SENSE_LVL_LO = 2'b10,
    SENSE_LVL_HI = 2'b11,
    SENSE_FALL   = 2'b00,
    SENSE_RISE   = 2'b01
  } sense_e;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/xint_detect.sv
module xint_detect
  import xint_pkg::*;
#(
  parameter int NUM_LINES = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] sync_in,
  input  logic [NUM_LINES-1:0] mode_lvl,
  input  logic [NUM_LINES-1:0] edge_pol,
  input  logic [NUM_LINES-1:0] lvl_pol,
  input  logic [NUM_LINES-1:0] clr_vec,
  output logic [NUM_LINES-1:0] status
);
  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] edge_evt;
  logic [NUM_LINES-1:0] lvl_act;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_in;
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    sense_e sense;
    assign sense = sense_e'({mode_lvl[g], mode_lvl[g] ? lvl_pol[g] : edge_pol[g]});

    always_comb begin
      edge_evt[g] = 1'b0;
      lvl_act[g]  = 1'b0;
      unique case (sense)
        SENSE_RISE:   edge_evt[g] = sync_in[g] & ~prev_q[g];
        SENSE_FALL:   edge_evt[g] = ~sync_in[g] & prev_q[g];
        SENSE_LVL_HI: lvl_act[g]  = sync_in[g];
        SENSE_LVL_LO: lvl_act[g]  = ~sync_in[g];
        default:      ;
      endcase
    end

    // edge events outrank a clear; level activity yields to it for one cycle
    always_ff @(posedge clk) begin
      if (rst) status[g] <= 1'b0;
      else     status[g] <= ((status[g] | lvl_act[g]) & ~clr_vec[g]) | edge_evt[g];
    end
  end

  AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
    ((edge_evt & clr_vec) != '0) |=> ((status & $past(edge_evt & clr_vec)) == $past(edge_evt & clr_vec))); // R9
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & ($past(status) & ~$past(clr_vec))) == ($past(status) & ~$past(clr_vec)))); // R6
endmodule

// File: rtl/xint_regs.sv
module xint_regs
  import xint_pkg::*;
#(
  parameter int NUM_LINES = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] status,
  output logic [NUM_LINES-1:0] en_vec,
  output logic [NUM_LINES-1:0] mode_vec,
  output logic [NUM_LINES-1:0] edge_vec,
  output logic [NUM_LINES-1:0] lvl_vec,
  output logic [NUM_LINES-1:0] clr_vec,
  output logic                 nmi_en
);
  localparam logic [DATA_W-1:0] IMPL = DATA_W'((64'd1 << NUM_LINES) - 64'd1);

  logic [DATA_W-1:0] en_q, mode_q, edge_q, lvl_q, wmask, stat_w;
  logic              wr_hit, rd_hit;

  assign wr_hit = bus_sel & bus_wr;
  assign rd_hit = bus_sel & ~bus_wr;
  assign wmask  = bus_wdata & IMPL;
  assign stat_w = DATA_W'(status);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mode_q <= IMPL;
      edge_q <= '0;
      lvl_q  <= '0;
      nmi_en <= 1'b0;
    end else if (wr_hit) begin
      unique case (bus_addr)
        OFS_EN_SET: en_q   <= en_q | wmask;
        OFS_EN_CLR: en_q   <= en_q & ~wmask;
        OFS_MODE:   mode_q <= wmask;
        OFS_EDGE:   edge_q <= wmask;
        OFS_LEVEL:  lvl_q  <= wmask;
        OFS_NMI:    nmi_en <= bus_wdata[0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_hit) begin
      unique case (bus_addr)
        OFS_EN_RD: bus_rdata <= en_q;
        OFS_STAT:  bus_rdata <= stat_w;
        OFS_MODE:  bus_rdata <= mode_q;
        OFS_EDGE:  bus_rdata <= edge_q;
        OFS_LEVEL: bus_rdata <= lvl_q;
        OFS_NMI:   bus_rdata <= {{(DATA_W-1){1'b0}}, nmi_en};
        default:   bus_rdata <= '0;
      endcase
    end
  end

  assign clr_vec  = (wr_hit && bus_addr == OFS_ST_CLR) ? bus_wdata[NUM_LINES-1:0] : '0;
  assign en_vec   = en_q[NUM_LINES-1:0];
  assign mode_vec = mode_q[NUM_LINES-1:0];
  assign edge_vec = edge_q[NUM_LINES-1:0];
  assign lvl_vec  = lvl_q[NUM_LINES-1:0];

  AST_EN_SET_ONES: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && bus_addr == OFS_EN_SET) |=> ((en_vec & $past(bus_wdata[NUM_LINES-1:0])) == $past(bus_wdata[NUM_LINES-1:0]))); // R2
  AST_EN_CLR_ONES: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && bus_addr == OFS_EN_CLR) |=> ((en_vec & $past(bus_wdata[NUM_LINES-1:0])) == '0)); // R2
  AST_MODE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && bus_addr == OFS_MODE) |=> ((bus_rdata & ~IMPL) == '0)); // R12
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
  import xint_pkg::*;
#(
  parameter int NUM_LINES = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] ext_in,
  output logic                 irq_out,
  output logic                 nmi_out
);
  logic [NUM_LINES-1:0] sync_v, status, en_v, mode_v, edge_v, lvl_v, clr_v;
  logic                 nmi_en;

  xint_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk(clk), .rst(rst), .async_in(ext_in), .sync_out(sync_v)
  );

  xint_detect #(.NUM_LINES(NUM_LINES)) u_detect (
    .clk(clk), .rst(rst), .sync_in(sync_v), .mode_lvl(mode_v),
    .edge_pol(edge_v), .lvl_pol(lvl_v), .clr_vec(clr_v), .status(status)
  );

  xint_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .status(status), .en_vec(en_v), .mode_vec(mode_v), .edge_vec(edge_v),
    .lvl_vec(lvl_v), .clr_vec(clr_v), .nmi_en(nmi_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out <= 1'b0;
      nmi_out <= 1'b0;
    end else begin
      irq_out <= |(status & en_v);
      nmi_out <= nmi_en & status[0];
    end
  end

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(|(status & en_v)))); // R10
  AST_NMI_GATED: assert property (@(posedge clk) disable iff (rst)
    nmi_out |-> ($past(nmi_en) && $past(status[0]))); // R11
endmodule

// File: tb/xint_ctrl_tb.sv
module xint_ctrl_tb;
  localparam int NL = 12;
  localparam logic [31:0] ALL = 32'h0000_0FFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] ext_in = '1;
  logic          irq_out, nmi_out;
  int            errors = 0, checks = 0;

  always #5 clk = ~clk;

  xint_ctrl #(.NUM_LINES(NL)) u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_in(ext_in), .irq_out(irq_out), .nmi_out(nmi_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset;
    check("R1 irq after reset", {31'b0, irq_out}, 32'd0);
    check("R1 nmi after reset", {31'b0, nmi_out}, 32'd0);
    rd_chk("R1 mode reset", 8'h14, ALL);
    rd_chk("R1 edge reset", 8'h18, 32'd0);
    rd_chk("R1 level reset", 8'h1C, 32'd0);
    rd_chk("R1 enable reset", 8'h08, 32'd0);
    rd_chk("R1 nmi ctrl reset", 8'h24, 32'd0);
    wait_cyc(3);
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk("R4 status cleared", 8'h0C, 32'd0);
  endtask

  task automatic t_enables;
    wr(8'h00, 32'h5);        rd_chk("R2 set ones", 8'h08, 32'h5);
    wr(8'h00, 32'h0);        rd_chk("R2 set zeros no effect", 8'h08, 32'h5);
    wr(8'h00, 32'h2);        rd_chk("R3 readback merge", 8'h08, 32'h7);
    wr(8'h04, 32'h4);        rd_chk("R2 clear one", 8'h08, 32'h3);
    wr(8'h04, 32'h0);        rd_chk("R2 clear zeros no effect", 8'h08, 32'h3);
    wr(8'h00, 32'hFFFF_FFFF); rd_chk("R12 enable upper ignored", 8'h08, ALL);
    wr(8'h04, 32'hFFFF_FFFF); rd_chk("R2 clear all", 8'h08, 32'd0);
  endtask

  task automatic t_width;
    wr(8'h14, 32'hFFFF_FFFF); rd_chk("R12 mode reveals count", 8'h14, ALL);
    wr(8'h18, 32'hFFFF_F000); rd_chk("R12 edge upper ignored", 8'h18, 32'd0);
    wr(8'h1C, 32'hFFFF_F000); rd_chk("R12 level upper ignored", 8'h1C, 32'd0);
  endtask

  task automatic t_level;
    wr(8'h1C, 32'h2);               // line 1 active high, input already high
    wait_cyc(2);
    rd_chk("R5 level high latches", 8'h0C, 32'h2);
    wr(8'h10, 32'h2);
    rd_chk("R8 cleared reads 0", 8'h0C, 32'h0);
    rd_chk("R8 sets again", 8'h0C, 32'h2);
    ext_in[2] = 1'b0;               // line 2 active low
    wait_cyc(4);
    rd_chk("R5 level low latches", 8'h0C, 32'h6);
    ext_in[2] = 1'b1;
    wait_cyc(4);
    wr(8'h10, 32'h4);
    wait_cyc(1);
    rd_chk("R4 clear leaves others", 8'h0C, 32'h2);
    check("R10 irq masked", {31'b0, irq_out}, 32'd0);
    wr(8'h00, 32'h2);
    wait_cyc(1);
    check("R10 irq enabled line", {31'b0, irq_out}, 32'd1);
    wr(8'h04, 32'h2);
    wait_cyc(1);
    check("R10 irq after disable", {31'b0, irq_out}, 32'd0);
    wr(8'h1C, 32'h0);
    wr(8'h10, ALL);
  endtask

  task automatic t_edge;
    wr(8'h14, ALL & ~32'h8);        // line 3 edge mode
    wr(8'h18, 32'h8);               // rising
    ext_in[3] = 1'b0;
    wait_cyc(4);
    rd_chk("R6 falling ignored when rising", 8'h0C, 32'h0);
    wr(8'h00, 32'h8);
    ext_in[3] = 1'b1;
    wait_cyc(3);
    check("R7 irq not yet", {31'b0, irq_out}, 32'd0);
    wait_cyc(1);
    check("R7 irq at k+3", {31'b0, irq_out}, 32'd1);
    ext_in[3] = 1'b0;
    wait_cyc(4);
    rd_chk("R6 rising latched after return", 8'h0C, 32'h8);
    wr(8'h10, 32'h8);
    wr(8'h18, 32'h0);               // falling
    ext_in[3] = 1'b1;
    wait_cyc(4);
    rd_chk("R6 rising ignored when falling", 8'h0C, 32'h0);
    ext_in[3] = 1'b0;
    wait_cyc(4);
    rd_chk("R6 falling latched", 8'h0C, 32'h8);
    wr(8'h10, 32'h8);
    wr(8'h04, ALL);
  endtask

  task automatic t_coincide;
    wr(8'h18, 32'h8);               // rising; input low and settled
    wait_cyc(3);
    wr(8'h10, ALL);
    rd_chk("R9 baseline clear", 8'h0C, 32'h0);
    ext_in[3] = 1'b1;               // sampled at edge k
    wait_cyc(2);
    wr(8'h10, 32'h8);               // write lands on edge k+2
    rd_chk("R9 edge beats clear", 8'h0C, 32'h8);
    wr(8'h10, 32'h8);
    rd_chk("R9 later clear works", 8'h0C, 32'h0);
  endtask

  task automatic t_nmi;
    wr(8'h24, 32'h1);
    rd_chk("R11 nmi ctrl readback", 8'h24, 32'h1);
    ext_in[0] = 1'b0;               // line 0 low level
    wait_cyc(5);
    check("R11 nmi asserted", {31'b0, nmi_out}, 32'd1);
    check("R11 irq stays masked", {31'b0, irq_out}, 32'd0);
    wr(8'h24, 32'h0);
    wait_cyc(1);
    check("R11 nmi disabled", {31'b0, nmi_out}, 32'd0);
    ext_in[0] = 1'b1;
    wait_cyc(4);
    wr(8'h10, ALL);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enables();
    t_width();
    t_level();
    t_edge();
    t_coincide();
    t_nmi();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule